// File: doc/BRIEF.md
# Instruction Address Match Trap Unit

This block watches the start address of every instruction that the core is about to execute. It compares that address against four programmable match channels. Each channel has a 20-bit address register and an enable bit of its own. When an enabled channel holds the address of the instruction that is starting, the unit raises a trap request before that instruction runs. The request has no mask input. The global interrupt-enable flag and the current priority level never reach it, so it cannot be held off or filtered.

Along with the request, the unit reports which channel matched and the return address that the core should push on the stack. The return address is the matched address plus 2 for instructions in the long opcode class and plus 1 for all others. A match is suppressed when the external data bus runs 8 bits wide and the address lies in the external area. The stack push, the vector fetch and the opcode decoding happen outside this block.

Software programs the channels through a one-cycle write port. Selectors 0 to 3 address the match registers. Selector 4 holds the enables of channels 0 and 1. Selector 5 holds the enables of channels 2 and 3.

Top module: `iam_trap_unit`

## Requirements
- R1: After reset, trap_req, trap_chan and trap_ret are all zero, every enable is clear and every match register is zero, so a strobe at address 0 raises no request.
- R2: A strobe whose address equals an enabled channel's register on all 20 bits drives trap_req high for exactly the cycle after the strobe. A difference in any single bit gives no request.
- R3: A write with cfg_sel=4 loads the enables of channels 0 and 1 from cfg_wdata bits 0 and 1. A write with cfg_sel=5 loads the enables of channels 2 and 3 from bits 0 and 1. A write with cfg_sel 0 to 3 loads that channel's match register. Each enable bit gates only its own channel.
- R4: A channel whose enable bit is clear never raises a request, even when its register matches.
- R5: With a request, trap_ret is the matched address plus 2 when op_long was 1 in the strobe cycle, and plus 1 when it was 0. The sum wraps modulo 2^20.
- R6: A strobe with bus8_mode=1 and addr_is_ext=1 in the same cycle raises no request. Either signal alone does not block.
- R7: When several enabled channels match, a single request is raised and trap_chan gives the lowest-numbered matching channel.
- R8: No request follows a cycle without ifetch_start. Each strobe yields at most one single-cycle pulse.
- R9: trap_chan and trap_ret keep their values in cycles with no request.
- R10: A strobe in the same cycle as a configuration write is compared against the contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Write target: 0-3 match register, 4 enables 0/1, 5 enables 2/3 |
| cfg_wdata | input | 20 | Write data |
| ifetch_start | input | 1 | An instruction starts at ifetch_addr in this cycle |
| ifetch_addr | input | 20 | Start address of the next instruction |
| op_long | input | 1 | Opcode class: 1 = return offset +2, 0 = +1 |
| bus8_mode | input | 1 | External data bus is 8 bits wide |
| addr_is_ext | input | 1 | ifetch_addr lies in the external area |
| trap_req | output | 1 | Single-cycle trap request |
| trap_chan | output | 2 | Lowest matching channel of the last request |
| trap_ret | output | 20 | Return address of the last request |

## Verification
All three outputs are registered. A strobe that hits at rising edge k shows trap_req, trap_chan and trap_ret at edge k, and the bench reads them at the falling edge that follows. A configuration write becomes visible to strobes from the next cycle onward, which is why a strobe in the write cycle still sees the old value. The bench's reference model advances on the same rising edge from the inputs it drove, and it is compared with the ports at every falling edge. This way each result is checked exactly in the cycle it is due, and it is checked again in each later cycle where it must hold.

// File: rtl/iam_pkg.sv
package iam_pkg;
  // enable bits packed into each control register
  localparam int unsigned EN_PER_CTRL = 2;

  // return offset chosen by opcode class
  function automatic logic [1:0] ret_step(input logic long_op);
    return long_op ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/iam_cfg_bank.sv
module iam_cfg_bank #(
  parameter int unsigned AW   = 20,
  parameter int unsigned NCH  = 4,
  parameter int unsigned SELW = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [SELW-1:0]         cfg_sel,
  input  logic [AW-1:0]           cfg_wdata,
  output logic [NCH-1:0][AW-1:0]  match_q,
  output logic [NCH-1:0]          en_q
);
  import iam_pkg::*;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned CTRL_SEL = NCH + c / EN_PER_CTRL;
    localparam int unsigned CTRL_BIT = c % EN_PER_CTRL;
    logic [AW-1:0] m_r;
    logic          e_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m_r <= '0;
        e_r <= 1'b0;
      end else if (cfg_we) begin
        if (cfg_sel == SELW'(c))        m_r <= cfg_wdata;
        if (cfg_sel == SELW'(CTRL_SEL)) e_r <= cfg_wdata[CTRL_BIT];
      end
    end

    assign match_q[c] = m_r;
    assign en_q[c]    = e_r;
  end
endmodule

// File: rtl/iam_chan_cmp.sv
module iam_chan_cmp #(
  parameter int unsigned AW = 20
) (
  input  logic          en,
  input  logic [AW-1:0] match,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  assign hit = en && (addr == match);
endmodule

// File: rtl/iam_lowest_pick.sv
module iam_lowest_pick #(
  parameter int unsigned NCH = 4,
  parameter int unsigned IW  = 2
) (
  input  logic [NCH-1:0] req,
  output logic           any,
  output logic [IW-1:0]  idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/iam_trap_unit.sv
module iam_trap_unit #(
  parameter  int unsigned AW   = 20,
  parameter  int unsigned NCH  = 4,
  localparam int unsigned NGRP = (NCH + 1) / 2,
  localparam int unsigned SELW = $clog2(NCH + NGRP),
  localparam int unsigned IW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  input  logic            ifetch_start,
  input  logic [AW-1:0]   ifetch_addr,
  input  logic            op_long,
  input  logic            bus8_mode,
  input  logic            addr_is_ext,
  output logic            trap_req,
  output logic [IW-1:0]   trap_chan,
  output logic [AW-1:0]   trap_ret
);
  import iam_pkg::*;

  function automatic logic [AW-1:0] ret_of(input logic [AW-1:0] a, input logic long_op);
    return a + AW'(ret_step(long_op));
  endfunction

  logic [NCH-1:0][AW-1:0] match_q;
  logic [NCH-1:0]         en_q;
  logic [NCH-1:0]         hit_vec;
  logic                   hit_any;
  logic [IW-1:0]          pick_idx;
  logic                   ext_block;
  logic                   fire;

  iam_cfg_bank #(.AW(AW), .NCH(NCH), .SELW(SELW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_sel  (cfg_sel),
    .cfg_wdata(cfg_wdata),
    .match_q  (match_q),
    .en_q     (en_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    iam_chan_cmp #(.AW(AW)) u_cmp (
      .en   (en_q[c]),
      .match(match_q[c]),
      .addr (ifetch_addr),
      .hit  (hit_vec[c])
    );
  end

  iam_lowest_pick #(.NCH(NCH), .IW(IW)) u_pick (
    .req(hit_vec),
    .any(hit_any),
    .idx(pick_idx)
  );

  assign ext_block = bus8_mode && addr_is_ext;
  assign fire      = ifetch_start && hit_any && !ext_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req  <= 1'b0;
      trap_chan <= '0;
      trap_ret  <= '0;
    end else begin
      trap_req <= fire;
      if (fire) begin
        trap_chan <= pick_idx;
        trap_ret  <= ret_of(ifetch_addr, op_long);
      end
    end
  end
endmodule

// File: rtl/iam_trap_chk.sv
module iam_trap_chk #(
  parameter int unsigned AW  = 20,
  parameter int unsigned NCH = 4,
  parameter int unsigned IW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ifetch_start,
  input logic [AW-1:0]  ifetch_addr,
  input logic           op_long,
  input logic           bus8_mode,
  input logic           addr_is_ext,
  input logic [NCH-1:0] hit_vec,
  input logic           trap_req,
  input logic [IW-1:0]  trap_chan,
  input logic [AW-1:0]  trap_ret
);
  // R8
  req_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(ifetch_start) && $past(|hit_vec));

  // R2
  hit_raises_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ifetch_start && (|hit_vec) && !(bus8_mode && addr_is_ext)) |=> trap_req);

  // R6
  ext_narrow_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ifetch_start && bus8_mode && addr_is_ext) |=> !trap_req);

  // R5
  ret_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> trap_ret == $past(ifetch_addr) + ($past(op_long) ? AW'(2) : AW'(1)));

  // R7
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && $past(hit_vec[0])) |-> trap_chan == '0);

  // R9
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |-> $stable(trap_ret) && $stable(trap_chan));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && !ifetch_start) |=> !trap_req);
endmodule

bind iam_trap_unit iam_trap_chk #(.AW(AW), .NCH(NCH), .IW(IW)) u_trap_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ifetch_start(ifetch_start),
  .ifetch_addr (ifetch_addr),
  .op_long     (op_long),
  .bus8_mode   (bus8_mode),
  .addr_is_ext (addr_is_ext),
  .hit_vec     (hit_vec),
  .trap_req    (trap_req),
  .trap_chan   (trap_chan),
  .trap_ret    (trap_ret)
);

// File: tb/test_iam_trap_unit.sv
module test_iam_trap_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [19:0] cfg_wdata = '0;
  logic        ifetch_start = 1'b0;
  logic [19:0] ifetch_addr = '0;
  logic        op_long = 1'b0;
  logic        bus8_mode = 1'b0;
  logic        addr_is_ext = 1'b0;
  logic        trap_req;
  logic [1:0]  trap_chan;
  logic [19:0] trap_ret;

  always #5 clk = ~clk;

  iam_trap_unit i_iam_trap_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ifetch_start(ifetch_start), .ifetch_addr(ifetch_addr),
    .op_long(op_long), .bus8_mode(bus8_mode), .addr_is_ext(addr_is_ext),
    .trap_req(trap_req), .trap_chan(trap_chan), .trap_ret(trap_ret)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cyc     = 0;
  string tag     = "R1";

  // behavioural reference model
  int unsigned m_reg [4];
  bit          m_en  [4];
  bit          e_req  = 0;
  int unsigned e_chan = 0;
  int unsigned e_ret  = 0;

  always @(posedge clk or negedge rst_n) begin
    int first;
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin m_reg[c] = 0; m_en[c] = 0; end
      e_req = 0; e_chan = 0; e_ret = 0;
    end else begin
      first = -1;
      for (int c = 0; c < 4; c++)
        if (first < 0 && m_en[c] && m_reg[c] == int'(ifetch_addr)) first = c;
      e_req = ifetch_start && first >= 0 && !(bus8_mode && addr_is_ext);
      if (e_req) begin
        e_chan = first;
        e_ret  = (int'(ifetch_addr) + (op_long ? 2 : 1)) % (1 << 20);
      end
      if (cfg_we) begin
        if (cfg_sel < 4) m_reg[cfg_sel] = cfg_wdata;
        else if (cfg_sel == 4) begin m_en[0] = cfg_wdata[0]; m_en[1] = cfg_wdata[1]; end
        else if (cfg_sel == 5) begin m_en[2] = cfg_wdata[0]; m_en[3] = cfg_wdata[1]; end
      end
    end
  end

  task automatic chk(input string what, input int unsigned act, input int unsigned exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL [%s] %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    chk("trap_req", trap_req, e_req);
    chk("trap_chan", trap_chan, e_chan);
    chk("trap_ret", trap_ret, e_ret);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL [R8] watchdog: actual %0d cycles expected below 20000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step(input bit st, input logic [19:0] a, input bit lg, input bit b8,
                      input bit ex, input bit we, input logic [2:0] sel, input logic [19:0] d);
    @(negedge clk);
    ifetch_start = st; ifetch_addr = a; op_long = lg; bus8_mode = b8; addr_is_ext = ex;
    cfg_we = we; cfg_sel = sel; cfg_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 20'h0, 0, 0, 0, 0, 3'd0, 20'h0);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [19:0] d);
    step(0, 20'h0, 0, 0, 0, 1, sel, d);
  endtask

  task automatic fetch(input logic [19:0] a, input bit lg, input bit b8, input bit ex);
    step(1, a, lg, b8, ex, 0, 3'd0, 20'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, zero registers and clear enables
    tag = "R1";
    fetch(20'h00000, 0, 0, 0); idle(2);
    // R3: program match registers
    tag = "R3";
    wr(3'd0, 20'h12345); wr(3'd1, 20'h00ABC); wr(3'd2, 20'hFFFFF); wr(3'd3, 20'h12345);
    // R4: all disabled
    tag = "R4";
    fetch(20'h12345, 0, 0, 0); fetch(20'hFFFFF, 1, 0, 0); idle(2);
    // R2: enable channel 0, exact and near-miss addresses
    tag = "R2";
    wr(3'd4, 20'h1);
    fetch(20'h12345, 0, 0, 0); idle(1);
    fetch(20'h12344, 0, 0, 0); fetch(20'h92345, 0, 0, 0); fetch(20'h12346, 0, 0, 0); idle(1);
    // R9: outputs hold with no request
    tag = "R9";
    fetch(20'h00ABC, 1, 0, 0); idle(3);
    // R7: channels 0 and 3 both match
    tag = "R7";
    wr(3'd5, 20'h2);
    fetch(20'h12345, 1, 0, 0); idle(1);
    // R3: enable bits gate only their own channel
    tag = "R3";
    wr(3'd4, 20'h2);
    fetch(20'h12345, 0, 0, 0); fetch(20'h00ABC, 0, 0, 0); idle(1);
    // R5: +2 with wrap, then +1
    tag = "R5";
    wr(3'd5, 20'h3);
    fetch(20'hFFFFF, 1, 0, 0); fetch(20'hFFFFF, 0, 0, 0); idle(1);
    // R6: narrow bus with external area
    tag = "R6";
    fetch(20'h00ABC, 0, 1, 1); idle(1);
    fetch(20'h00ABC, 0, 1, 0); fetch(20'h00ABC, 1, 0, 1); idle(1);
    // R8: address held without strobe, then back-to-back strobes
    tag = "R8";
    step(0, 20'h00ABC, 0, 0, 0, 0, 3'd0, 20'h0);
    step(0, 20'h00ABC, 0, 0, 0, 0, 3'd0, 20'h0);
    fetch(20'h00ABC, 0, 0, 0); fetch(20'h00ABC, 1, 0, 0); idle(2);
    // R10: write and strobe in one cycle
    tag = "R10";
    step(1, 20'h00777, 0, 0, 0, 1, 3'd1, 20'h00777); idle(1);
    fetch(20'h00777, 0, 0, 0); idle(1);
    step(1, 20'h00777, 0, 0, 0, 1, 3'd4, 20'h0); idle(1);
    fetch(20'h00777, 0, 0, 0); idle(1);
    // R2: mixed traffic from a small address set
    tag = "R2";
    for (int i = 0; i < 400; i++) begin
      logic [19:0] pool [5];
      pool[0] = 20'h12345; pool[1] = 20'h00777; pool[2] = 20'hFFFFF;
      pool[3] = 20'h00ABC; pool[4] = 20'h12340;
      if ($urandom_range(0, 9) == 0)
        step($urandom_range(0, 1), pool[$urandom_range(0, 4)], $urandom_range(0, 1), 0, 0,
             1, 3'($urandom_range(0, 6)), 20'($urandom_range(0, 3)));
      else
        step($urandom_range(0, 1), pool[$urandom_range(0, 4)], $urandom_range(0, 1),
             $urandom_range(0, 1), $urandom_range(0, 1), 0, 3'd0, 20'h0);
    end
    idle(3);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule